// File: doc/BRIEF.md
# Uncached Load Request Queue

This block is a small pool of request slots that sits between a load pipeline and a buffer that carries uncached reads onto the bus. The pipeline hands over a load (address plus a pipeline tag). The block parks it in a free slot and forwards it to the bus buffer, tagged with the slot number. When the buffer answers, the slot number on the response routes the data back to its slot. The block then hands the tag and data back to the pipeline on a writeback port, and the slot returns to the pool.

Slots are not used in arrival order. A free-slot bit vector hands out the lowest free slot, and each slot runs its own state machine. That machine has five states. ST_IDLE means the slot is free. ST_WAIT_SEND means it waits for its turn on the bus request port. ST_WAIT_RESP means its request has been accepted and it waits for data. ST_WAIT_WB means it holds data and waits for the writeback port. ST_DRAIN means it was flushed after its request left, and it waits only to swallow the response.

The transitions are as follows:
- alloc: IDLE→WAIT_SEND.
- sent: WAIT_SEND→WAIT_RESP.
- respond: WAIT_RESP→WAIT_WB.
- writeback: WAIT_WB→IDLE.
- kill: WAIT_SEND or WAIT_WB→IDLE on flush.
- orphan: WAIT_RESP→DRAIN on flush, and WAIT_SEND→DRAIN on a flush in the same cycle the request is accepted.
- swallow: DRAIN→IDLE on the response, or WAIT_RESP→IDLE when the response and the flush coincide.

Two central arbiters pick the lowest-index candidate for the bus port and for the writeback port. Each arbiter locks its choice until the handshake completes. A flush clears every live slot.

Top module: `uncached_load_queue`

## Requirements
- R1: After reset, req_ready is 1 and both bus_req_valid and wb_valid are 0.
- R2: Once all NUM_ENTRIES slots are occupied, req_ready is 0.
- R3: An accepted request takes the lowest-numbered free slot, and that slot number is the bus_req_id it later carries.
- R4: bus_req_valid offers the lowest-numbered slot waiting to send. While bus_req_ready is 0 and no flush occurs, bus_req_id and bus_req_addr stay unchanged.
- R5: A response (rsp_valid with rsp_id) is routed to slot rsp_id. That slot's writeback carries the tag of its own request and the response data, whatever order the responses come back in.
- R6: At most one writeback per cycle. Once wb_valid is shown with wb_ready 0, wb_tag and wb_data stay unchanged until the handshake. When it completes, the lowest-numbered waiting slot goes next.
- R7: A slot is returned to the pool at the clock edge of its writeback handshake, so a full queue shows req_ready 1 in the following cycle.
- R8: A flush returns slots that have not yet sent, and slots holding data, to the free pool. They produce no bus request and no writeback.
- R9: A slot flushed after its request was accepted stays occupied until its response arrives. It then frees itself and produces no writeback.
- R10: During a flush cycle req_ready is 0, and a request offered in that cycle is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Kills every live slot |
| req_valid | input | 1 | Pipeline offers an uncached load |
| req_ready | output | 1 | A slot is free and no flush is in progress |
| req_addr | input | ADDR_W | Load address |
| req_tag | input | TAG_W | Pipeline tag returned at writeback |
| bus_req_valid | output | 1 | A slot offers its request to the bus buffer |
| bus_req_ready | input | 1 | Bus buffer accepts the request |
| bus_req_id | output | $clog2(NUM_ENTRIES) | Slot number of the offered request |
| bus_req_addr | output | ADDR_W | Address of the offered request |
| rsp_valid | input | 1 | Bus buffer returns data |
| rsp_id | input | $clog2(NUM_ENTRIES) | Slot the data belongs to |
| rsp_data | input | DATA_W | Returned load data |
| wb_valid | output | 1 | A completed load is offered to the pipeline |
| wb_ready | input | 1 | Pipeline accepts the writeback |
| wb_tag | output | TAG_W | Tag of the completed load |
| wb_data | output | DATA_W | Data of the completed load |

## Verification
Every cycle, the assertions check three things: the bus request and the writeback hold still while stalled, the free-slot vector agrees with which slot machines are idle, and an arbiter grant only ever reaches a slot in the matching state. The bench scenarios cover the rest. These include which slot a request lands in and which slot a freed one is reused as. They also cover writeback order under out-of-order responses and a stalled writeback port, the tag and data pairing, and flushes in every state, including the draining slot that keeps the queue full until its orphan response arrives.

// File: rtl/ulq_pkg.sv
package ulq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_SEND,
        ST_WAIT_RESP,
        ST_WAIT_WB,
        ST_DRAIN
    } ulq_state_e;
endpackage

// File: rtl/ulq_free_list.sv
module ulq_free_list #(
    parameter int N   = 4,
    parameter int IDW = $clog2(N)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           alloc_i,
    input  logic [N-1:0]   release_i,
    output logic           avail_o,
    output logic [IDW-1:0] alloc_id_o,
    output logic [N-1:0]   free_o
);
    logic [N-1:0] free_q;
    logic [N-1:0] take_mask;

    // lowest free slot wins
    always_comb begin
        alloc_id_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (free_q[i]) alloc_id_o = IDW'(i);
        end
        avail_o   = |free_q;
        take_mask = alloc_i ? (N'(1) << alloc_id_o) : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) free_q <= '1;
        else        free_q <= (free_q & ~take_mask) | release_i;
    end

    assign free_o = free_q;

    // R7
    release_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (release_i & free_q) == '0);
endmodule

// File: rtl/ulq_hold_arb.sv
module ulq_hold_arb #(
    parameter int N   = 4,
    parameter int IDW = $clog2(N)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           flush_i,
    input  logic [N-1:0]   pending_i,
    input  logic           ready_i,
    output logic           valid_o,
    output logic [IDW-1:0] id_o
);
    logic           lock_q;
    logic [IDW-1:0] lock_id_q;
    logic [IDW-1:0] low_id;

    always_comb begin
        low_id = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pending_i[i]) low_id = IDW'(i);
        end
        valid_o = lock_q | (|pending_i);
        id_o    = lock_q ? lock_id_q : low_id;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            lock_q    <= 1'b0;
            lock_id_q <= '0;
        end else if (valid_o && !ready_i) begin
            lock_q    <= 1'b1;
            lock_id_q <= id_o;
        end else begin
            lock_q    <= 1'b0;
        end
    end

    // R4
    lock_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |-> pending_i[lock_id_q]);
endmodule

// File: rtl/ulq_entry.sv
module ulq_entry
    import ulq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64,
    parameter int TAG_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_i,
    input  logic [ADDR_W-1:0] alloc_addr_i,
    input  logic [TAG_W-1:0]  alloc_tag_i,
    input  logic              flush_i,
    input  logic              sent_i,
    input  logic              rsp_hit_i,
    input  logic [DATA_W-1:0] rsp_data_i,
    input  logic              wb_done_i,
    output ulq_state_e        state_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [TAG_W-1:0]  tag_o,
    output logic [DATA_W-1:0] data_o,
    output logic              release_o
);
    ulq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (alloc_i) state_d = ST_WAIT_SEND;
            ST_WAIT_SEND: begin
                if (flush_i)     state_d = sent_i ? ST_DRAIN : ST_IDLE;
                else if (sent_i) state_d = ST_WAIT_RESP;
            end
            ST_WAIT_RESP: begin
                if (rsp_hit_i)    state_d = flush_i ? ST_IDLE : ST_WAIT_WB;
                else if (flush_i) state_d = ST_DRAIN;
            end
            ST_WAIT_WB:   if (flush_i || wb_done_i) state_d = ST_IDLE;
            ST_DRAIN:     if (rsp_hit_i) state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_o <= '0;
            tag_o  <= '0;
            data_o <= '0;
        end else begin
            if (alloc_i && state_q == ST_IDLE) begin
                addr_o <= alloc_addr_i;
                tag_o  <= alloc_tag_i;
            end
            if (rsp_hit_i && state_q == ST_WAIT_RESP) data_o <= rsp_data_i;
        end
    end

    always_comb begin
        state_o   = state_q;
        release_o = (state_q != ST_IDLE) && (state_d == ST_IDLE);
    end

    // R4
    sent_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sent_i |-> state_q == ST_WAIT_SEND);
    // R6
    wb_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_done_i |-> state_q == ST_WAIT_WB);
endmodule

// File: rtl/uncached_load_queue.sv
module uncached_load_queue
    import ulq_pkg::*;
#(
    parameter int NUM_ENTRIES = 4,
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 64,
    parameter int TAG_W       = 8,
    localparam int IDW        = $clog2(NUM_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [TAG_W-1:0]  req_tag,
    output logic              bus_req_valid,
    input  logic              bus_req_ready,
    output logic [IDW-1:0]    bus_req_id,
    output logic [ADDR_W-1:0] bus_req_addr,
    input  logic              rsp_valid,
    input  logic [IDW-1:0]    rsp_id,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              wb_valid,
    input  logic              wb_ready,
    output logic [TAG_W-1:0]  wb_tag,
    output logic [DATA_W-1:0] wb_data
);
    localparam int N = NUM_ENTRIES;

    ulq_state_e        ent_st   [N];
    logic [ADDR_W-1:0] ent_addr [N];
    logic [TAG_W-1:0]  ent_tag  [N];
    logic [DATA_W-1:0] ent_data [N];
    logic [N-1:0]      release_v, send_pend, wb_pend, free_v;
    logic              avail, req_fire, bus_fire, wb_fire;
    logic [IDW-1:0]    alloc_id, wb_id;

    assign req_ready = avail && !flush;
    assign req_fire  = req_valid && req_ready;
    assign bus_fire  = bus_req_valid && bus_req_ready;
    assign wb_fire   = wb_valid && wb_ready;

    ulq_free_list #(.N(N), .IDW(IDW)) u_free (
        .clk(clk), .rst_n(rst_n), .alloc_i(req_fire), .release_i(release_v),
        .avail_o(avail), .alloc_id_o(alloc_id), .free_o(free_v)
    );

    for (genvar g = 0; g < N; g++) begin : g_ent
        ulq_entry #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_ent (
            .clk(clk), .rst_n(rst_n),
            .alloc_i(req_fire && alloc_id == IDW'(g)),
            .alloc_addr_i(req_addr), .alloc_tag_i(req_tag),
            .flush_i(flush),
            .sent_i(bus_fire && bus_req_id == IDW'(g)),
            .rsp_hit_i(rsp_valid && rsp_id == IDW'(g)),
            .rsp_data_i(rsp_data),
            .wb_done_i(wb_fire && wb_id == IDW'(g)),
            .state_o(ent_st[g]), .addr_o(ent_addr[g]), .tag_o(ent_tag[g]),
            .data_o(ent_data[g]), .release_o(release_v[g])
        );
        assign send_pend[g] = ent_st[g] == ST_WAIT_SEND;
        assign wb_pend[g]   = ent_st[g] == ST_WAIT_WB;

        // R2
        free_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
            free_v[g] == (ent_st[g] == ST_IDLE));
    end

    ulq_hold_arb #(.N(N), .IDW(IDW)) u_send_arb (
        .clk(clk), .rst_n(rst_n), .flush_i(flush), .pending_i(send_pend),
        .ready_i(bus_req_ready), .valid_o(bus_req_valid), .id_o(bus_req_id)
    );

    ulq_hold_arb #(.N(N), .IDW(IDW)) u_wb_arb (
        .clk(clk), .rst_n(rst_n), .flush_i(flush), .pending_i(wb_pend),
        .ready_i(wb_ready), .valid_o(wb_valid), .id_o(wb_id)
    );

    assign bus_req_addr = ent_addr[bus_req_id];
    assign wb_tag       = ent_tag[wb_id];
    assign wb_data      = ent_data[wb_id];

    // R4
    bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_valid && !bus_req_ready && !flush |=>
            bus_req_valid && $stable(bus_req_id) && $stable(bus_req_addr));
    // R6
    wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid && !wb_ready && !flush |=>
            wb_valid && $stable(wb_tag) && $stable(wb_data));
endmodule

// File: tb/uncached_load_queue_tb.sv
module uncached_load_queue_tb;
    localparam int N = 4, AW = 32, DW = 64, TW = 8, IW = 2;

    logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
    logic req_valid = 1'b0, bus_req_ready = 1'b0, rsp_valid = 1'b0, wb_ready = 1'b1;
    logic [AW-1:0] req_addr = '0;
    logic [TW-1:0] req_tag = '0;
    logic [IW-1:0] rsp_id = '0;
    logic [DW-1:0] rsp_data = '0;
    logic req_ready, bus_req_valid, wb_valid;
    logic [IW-1:0] bus_req_id;
    logic [AW-1:0] bus_req_addr;
    logic [TW-1:0] wb_tag;
    logic [DW-1:0] wb_data;

    int n_chk = 0, n_fail = 0;
    logic [TW+DW-1:0] exp_q[$];

    always #4 clk = ~clk;

    uncached_load_queue #(.NUM_ENTRIES(N), .ADDR_W(AW), .DATA_W(DW), .TAG_W(TW)) u_dut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_tag(req_tag),
        .bus_req_valid(bus_req_valid), .bus_req_ready(bus_req_ready),
        .bus_req_id(bus_req_id), .bus_req_addr(bus_req_addr),
        .rsp_valid(rsp_valid), .rsp_id(rsp_id), .rsp_data(rsp_data),
        .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_tag(wb_tag), .wb_data(wb_data)
    );

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic issue(logic [AW-1:0] a, logic [TW-1:0] t);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_tag = t;
        #1 chk("R2", "req_ready on issue", 64'(req_ready), 64'd1);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic take(logic [IW-1:0] id, logic [AW-1:0] a);
        @(negedge clk);
        #1;
        chk("R4", "bus_req_valid", 64'(bus_req_valid), 64'd1);
        chk("R3", "bus_req_id", 64'(bus_req_id), 64'(id));
        chk("R4", "bus_req_addr", 64'(bus_req_addr), 64'(a));
        bus_req_ready = 1'b1;
        @(negedge clk);
        bus_req_ready = 1'b0;
    endtask

    task automatic respond(logic [IW-1:0] id, logic [DW-1:0] d);
        @(negedge clk);
        rsp_valid = 1'b1; rsp_id = id; rsp_data = d;
        @(negedge clk);
        rsp_valid = 1'b0;
    endtask

    task automatic expect_wb(logic [TW-1:0] t, logic [DW-1:0] d);
        exp_q.push_back({t, d});
    endtask

    task automatic pulse_flush_with_req(logic [AW-1:0] a, logic [TW-1:0] t);
        @(negedge clk);
        flush = 1'b1; req_valid = 1'b1; req_addr = a; req_tag = t;
        #1 chk("R10", "req_ready during flush", 64'(req_ready), 64'd0);
        @(negedge clk);
        flush = 1'b0; req_valid = 1'b0;
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (rst_n && wb_valid && wb_ready) begin
                if (exp_q.size() == 0) begin
                    chk("R8/R9", "unexpected writeback tag", 64'(wb_tag), 64'hFFFF);
                end else begin
                    logic [TW+DW-1:0] e;
                    e = exp_q.pop_front();
                    chk("R5", "wb_tag", 64'(wb_tag), 64'(e[TW+DW-1:DW]));
                    chk("R5", "wb_data", 64'(wb_data), e[DW-1:0]);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1", "req_ready after reset", 64'(req_ready), 64'd1);
        chk("R1", "bus_req_valid after reset", 64'(bus_req_valid), 64'd0);
        chk("R1", "wb_valid after reset", 64'(wb_valid), 64'd0);

        // single request with stalled bus port (R4 hold)
        issue(32'h100, 8'h01);
        @(negedge clk); #1;
        chk("R4", "held id", 64'(bus_req_id), 64'd0);
        @(negedge clk); #1;
        chk("R4", "held addr", 64'(bus_req_addr), 64'h100);
        take(0, 32'h100);
        expect_wb(8'h01, 64'hA1);
        respond(0, 64'hA1);
        repeat (3) @(negedge clk);

        // fill the queue, out-of-order responses
        for (int i = 0; i < N; i++) issue(32'h1000 + 32'(i * 16), 8'h10 + 8'(i));
        #1 chk("R2", "req_ready when full", 64'(req_ready), 64'd0);
        for (int i = 0; i < N; i++) take(IW'(i), 32'h1000 + 32'(i * 16));
        expect_wb(8'h12, 64'hB2);
        respond(2, 64'hB2);
        #1 chk("R7", "req_ready before wb edge", 64'(req_ready), 64'd0);
        @(negedge clk); #1;
        chk("R7", "req_ready after wb edge", 64'(req_ready), 64'd1);
        issue(32'h2000, 8'h20);
        take(2, 32'h2000);
        expect_wb(8'h10, 64'hB0); respond(0, 64'hB0);
        expect_wb(8'h13, 64'hB3); respond(3, 64'hB3);
        expect_wb(8'h11, 64'hB1); respond(1, 64'hB1);
        expect_wb(8'h20, 64'hC2); respond(2, 64'hC2);
        repeat (3) @(negedge clk);
        chk("R5", "scoreboard drained", 64'(exp_q.size()), 64'd0);

        // writeback arbitration with stalled writeback port
        for (int i = 0; i < N; i++) issue(32'h3000 + 32'(i), 8'h30 + 8'(i));
        for (int i = 0; i < N; i++) take(IW'(i), 32'h3000 + 32'(i));
        wb_ready = 1'b0;
        respond(3, 64'hD3); respond(1, 64'hD1); respond(0, 64'hD0); respond(2, 64'hD2);
        @(negedge clk); #1;
        chk("R6", "wb_valid while stalled", 64'(wb_valid), 64'd1);
        chk("R6", "first locked wb_tag", 64'(wb_tag), 64'h33);
        expect_wb(8'h33, 64'hD3); expect_wb(8'h30, 64'hD0);
        expect_wb(8'h31, 64'hD1); expect_wb(8'h32, 64'hD2);
        @(negedge clk);
        wb_ready = 1'b1;
        repeat (6) @(negedge clk);
        chk("R6", "scoreboard drained", 64'(exp_q.size()), 64'd0);

        // flush with one slot sending, one waiting for response
        issue(32'h4000, 8'h40);
        issue(32'h4100, 8'h41);
        take(0, 32'h4000);
        pulse_flush_with_req(32'h4200, 8'h42);
        #1;
        chk("R8", "bus_req_valid after flush", 64'(bus_req_valid), 64'd0);
        chk("R8", "req_ready after flush", 64'(req_ready), 64'd1);
        issue(32'h4300, 8'h43); issue(32'h4400, 8'h44); issue(32'h4500, 8'h45);
        #1 chk("R9", "draining slot keeps queue full", 64'(req_ready), 64'd0);
        take(1, 32'h4300); take(2, 32'h4400); take(3, 32'h4500);
        respond(0, 64'hDEAD);
        #1 chk("R9", "drained slot freed", 64'(req_ready), 64'd1);
        @(negedge clk); #1;
        chk("R9", "no writeback from drained slot", 64'(wb_valid), 64'd0);
        expect_wb(8'h43, 64'hE1); respond(1, 64'hE1);
        expect_wb(8'h44, 64'hE2); respond(2, 64'hE2);
        expect_wb(8'h45, 64'hE3); respond(3, 64'hE3);
        repeat (3) @(negedge clk);
        chk("R9", "scoreboard drained", 64'(exp_q.size()), 64'd0);

        // flush a slot holding data
        wb_ready = 1'b0;
        issue(32'h5000, 8'h50);
        take(0, 32'h5000);
        respond(0, 64'hF0);
        #1 chk("R8", "wb_valid before flush", 64'(wb_valid), 64'd1);
        pulse_flush_with_req(32'h5100, 8'h51);
        #1 chk("R8", "wb_valid after flush", 64'(wb_valid), 64'd0);
        wb_ready = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        chk("R8", "wb_valid stays low", 64'(wb_valid), 64'd0);
        chk("R8", "slot returned", 64'(req_ready), 64'd1);
        issue(32'h6000, 8'h60);
        take(0, 32'h6000);
        expect_wb(8'h60, 64'h66);
        respond(0, 64'h66);
        repeat (3) @(negedge clk);
        chk("R5", "final scoreboard drained", 64'(exp_q.size()), 64'd0);
        summary();
    end
endmodule